// File: doc/BRIEF.md
# Interleaved Four-Thread Accumulator Loop

This block is an accumulator datapath whose path from the ALU output back to the ALU A input is a chain of self-latching stages. One stage is registered per cycle, and the chain as a whole is one loop of `THREADS` cycles (four by default). Each stage stands for four clocking zones, so the default loop spans sixteen zones.

Because every stage holds its own value, one accumulator value per thread is in flight in the loop at all times. A free-running thread counter gives the issue slot of each cycle to the next thread in turn. The result is fixed barrel multithreading: each thread has one dependent operation in progress, and the ALU is busy in every cycle.

A clearing gate sits directly after the ALU output. An issue can ask that the value sent back for its thread be zeroed. The result of that issue is still reported unchanged, and the thread's next operation then sees A equal to zero. This costs no cycle, because the zeroed value travels through the same stages as any other. Every completed result leaves the loop tagged with its thread, and a zero flag and a negative flag are kept for each thread.

Top module: `mt_accum_loop`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, every thread accumulator is zero, `out_valid` is low, all `flag_zero` and `flag_neg` bits are low, and `cur_tid` is 0.
- R2: `cur_tid` advances by one, modulo `THREADS`, on every clock edge after reset. The issue inputs presented in a cycle belong to thread `cur_tid`.
- R3: An issue accepted in cycle c produces `out_valid` high in cycle c+THREADS, with `out_tid` equal to the issuing thread and `out_data` equal to its ALU result. A slot with no issue gives `out_valid` low THREADS cycles later.
- R4: `iss_op` selects the operation on A (the thread's accumulator) and B (`iss_b`). The codes are 0 = A+B, 1 = A−B, 2 = A AND B, 3 = A OR B, 4 = B, and 5 to 7 = A unchanged. Results wrap modulo 2^DW.
- R5: The A operand of an issue is the value its own thread left in the loop. Threads never see each other's values.
- R6: With `iss_zero_a` high, the issue's result is output unchanged, but the value returned to that thread is zero. Its next issue, THREADS cycles later, therefore uses A = 0.
- R7: A slot with `iss_valid` low leaves that thread's accumulator unchanged.
- R8: One cycle after a result is output, `flag_zero[t]` for its thread t shows whether `out_data` was zero, and `flag_neg[t]` shows its top bit. The flags of other threads keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| iss_valid | input | 1 | An operation is issued in this cycle's slot |
| iss_op | input | 3 | Operation code |
| iss_b | input | DW | B operand |
| iss_zero_a | input | 1 | Zero the value returned to this thread |
| cur_tid | output | $clog2(THREADS) | Thread owning this cycle's issue slot |
| out_valid | output | 1 | A result completes the loop this cycle |
| out_tid | output | $clog2(THREADS) | Thread of the completing result |
| out_data | output | DW | Completing result |
| flag_zero | output | THREADS | Per-thread zero flag of last result |
| flag_neg | output | THREADS | Per-thread negative flag of last result |

## Verification
The bench builds the block with its defaults, DW = 12 and THREADS = 4. Twelve bits make wraparound at 0xFFF and sign bit 11 easy to reach with small operands. Four threads let one scenario fill every slot with a different operation and show that values do not mix between threads. It also checks that a zeroed return and an idle slot each act only on their own thread, one full loop later.

// File: rtl/mt_accum_loop.sv
module mt_accum_loop #(
  parameter int DW = 12,
  parameter int THREADS = 4,
  localparam int TW = $clog2(THREADS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          iss_valid,
  input  logic [2:0]    iss_op,
  input  logic [DW-1:0] iss_b,
  input  logic          iss_zero_a,
  output logic [TW-1:0] cur_tid,
  output logic          out_valid,
  output logic [TW-1:0] out_tid,
  output logic [DW-1:0] out_data,
  output logic [THREADS-1:0] flag_zero,
  output logic [THREADS-1:0] flag_neg
);

  localparam logic [2:0] OP_ADD = 3'd0;
  localparam logic [2:0] OP_SUB = 3'd1;
  localparam logic [2:0] OP_AND = 3'd2;
  localparam logic [2:0] OP_OR  = 3'd3;
  localparam logic [2:0] OP_PSB = 3'd4;

  logic [DW-1:0] fb_q [THREADS];
  logic [DW-1:0] rs_q [THREADS];
  logic [TW-1:0] tg_q [THREADS];
  logic [THREADS-1:0] v_q, zr_q;
  logic [DW-1:0] op_a, alu;

  assign op_a = fb_q[THREADS-1];

  always_comb begin
    case (iss_op)
      OP_ADD:  alu = op_a + iss_b;
      OP_SUB:  alu = op_a - iss_b;
      OP_AND:  alu = op_a & iss_b;
      OP_OR:   alu = op_a | iss_b;
      OP_PSB:  alu = iss_b;
      default: alu = op_a;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) cur_tid <= '0;
    else     cur_tid <= cur_tid + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fb_q[0] <= '0;
      rs_q[0] <= '0;
      tg_q[0] <= '0;
      v_q[0]  <= 1'b0;
      zr_q[0] <= 1'b0;
    end else begin
      fb_q[0] <= iss_valid ? (iss_zero_a ? '0 : alu) : op_a;
      rs_q[0] <= iss_valid ? alu : op_a;
      tg_q[0] <= cur_tid;
      v_q[0]  <= iss_valid;
      zr_q[0] <= iss_valid & iss_zero_a;
    end
  end

  for (genvar i = 1; i < THREADS; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) begin
        fb_q[i] <= '0;
        rs_q[i] <= '0;
        tg_q[i] <= '0;
        v_q[i]  <= 1'b0;
        zr_q[i] <= 1'b0;
      end else begin
        fb_q[i] <= fb_q[i-1];
        rs_q[i] <= rs_q[i-1];
        tg_q[i] <= tg_q[i-1];
        v_q[i]  <= v_q[i-1];
        zr_q[i] <= zr_q[i-1];
      end
    end
  end

  assign out_valid = v_q[THREADS-1];
  assign out_data  = rs_q[THREADS-1];
  assign out_tid   = tg_q[THREADS-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_zero <= '0;
      flag_neg  <= '0;
    end else if (out_valid) begin
      flag_zero[out_tid] <= (out_data == '0);
      flag_neg[out_tid]  <= out_data[DW-1];
    end
  end

  AST_OUT_TAG: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_tid == cur_tid); // R3
  AST_TID_STEP: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> cur_tid == $past(cur_tid) + 1'b1); // R2
  AST_ZERO_RETURN: assert property (@(posedge clk) disable iff (rst)
    (v_q[THREADS-1] && zr_q[THREADS-1]) |-> op_a == '0); // R6
  AST_IDLE_KEEP: assert property (@(posedge clk) disable iff (rst)
    !iss_valid |=> fb_q[0] == $past(op_a)); // R7
  AST_FLAG_UPD: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> flag_zero[$past(out_tid)] == ($past(out_data) == '0)); // R8

endmodule

// File: tb/mt_accum_loop_test.sv
module mt_accum_loop_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic iss_valid = 1'b0;
  logic [2:0] iss_op = 3'd0;
  logic [11:0] iss_b = '0;
  logic iss_zero_a = 1'b0;
  logic [1:0] cur_tid, out_tid;
  logic out_valid;
  logic [11:0] out_data;
  logic [3:0] flag_zero, flag_neg;

  mt_accum_loop uut (
    .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_op(iss_op),
    .iss_b(iss_b), .iss_zero_a(iss_zero_a), .cur_tid(cur_tid),
    .out_valid(out_valid), .out_tid(out_tid), .out_data(out_data),
    .flag_zero(flag_zero), .flag_neg(flag_neg));

  always #5ns clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  logic [11:0] acc [4];
  bit pv [4];
  logic [11:0] pd [4];
  bit ez [4], en [4];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic [11:0] model(input logic [2:0] op, input logic [11:0] a, input logic [11:0] b);
    case (op)
      3'd0: return a + b;
      3'd1: return a - b;
      3'd2: return a & b;
      3'd3: return a | b;
      3'd4: return b;
      default: return a;
    endcase
  endfunction

  task automatic step(input bit v, input logic [2:0] op, input logic [11:0] b, input bit z, input string req);
    int t = cyc % 4;
    logic [11:0] r;
    check(cur_tid == 2'(t), "R2", cur_tid, t);
    check(out_valid == pv[t], "R3", out_valid, pv[t]);
    if (pv[t]) begin
      check(out_data == pd[t], req, out_data, pd[t]);
      check(out_tid == 2'(t), "R3", out_tid, t);
    end
    for (int k = 0; k < 4; k++) begin
      check(flag_zero[k] == ez[k], "R8", flag_zero[k], ez[k]);
      check(flag_neg[k] == en[k], "R8", flag_neg[k], en[k]);
    end
    if (pv[t]) begin
      ez[t] = (pd[t] == 12'd0);
      en[t] = pd[t][11];
    end
    if (v) begin
      r = model(op, acc[t], b);
      acc[t] = z ? 12'd0 : r;
      pv[t] = 1'b1;
      pd[t] = r;
    end else pv[t] = 1'b0;
    iss_valid = v; iss_op = op; iss_b = b; iss_zero_a = z;
    @(posedge clk);
    @(negedge clk);
    cyc++;
  endtask

  task automatic flush();
    for (int i = 0; i < 8; i++) step(1'b0, 3'd0, 12'd0, 1'b0, "R7");
  endtask

  task automatic t_reset();
    check(out_valid == 1'b0, "R1", out_valid, 0);
    check(flag_zero == 4'd0 && flag_neg == 4'd0, "R1", {flag_zero, flag_neg}, 0);
    check(cur_tid == 2'd0, "R1", cur_tid, 0);
    flush();
  endtask

  task automatic t_chain();
    for (int i = 0; i < 5; i++) begin
      step(1'b1, 3'd0, 12'd3, 1'b0, "R5");
      for (int j = 0; j < 3; j++) step(1'b0, 3'd0, 12'd0, 1'b0, "R7");
    end
    flush();
  endtask

  task automatic t_interleave();
    step(1'b1, 3'd4, 12'h0F0, 1'b0, "R4");
    step(1'b1, 3'd1, 12'd5,   1'b0, "R4");
    step(1'b1, 3'd4, 12'hFFF, 1'b0, "R4");
    step(1'b1, 3'd4, 12'h00A, 1'b0, "R4");
    step(1'b1, 3'd2, 12'h03C, 1'b0, "R4");
    step(1'b1, 3'd1, 12'h7F0, 1'b0, "R4");
    step(1'b1, 3'd0, 12'd1,   1'b0, "R4");
    step(1'b1, 3'd3, 12'h500, 1'b0, "R4");
    step(1'b1, 3'd6, 12'h123, 1'b0, "R4");
    step(1'b1, 3'd0, 12'd2,   1'b0, "R5");
    step(1'b1, 3'd5, 12'h777, 1'b0, "R4");
    step(1'b1, 3'd7, 12'h001, 1'b0, "R4");
    flush();
  endtask

  task automatic t_zero();
    step(1'b1, 3'd4, 12'h055, 1'b1, "R6");
    step(1'b1, 3'd4, 12'h066, 1'b0, "R6");
    step(1'b0, 3'd0, 12'd0, 1'b0, "R7");
    step(1'b1, 3'd4, 12'h088, 1'b1, "R6");
    step(1'b1, 3'd0, 12'd1, 1'b0, "R6");
    step(1'b1, 3'd0, 12'd1, 1'b0, "R6");
    step(1'b1, 3'd0, 12'd1, 1'b0, "R6");
    step(1'b1, 3'd0, 12'd1, 1'b0, "R6");
    flush();
  endtask

  task automatic t_idle();
    step(1'b1, 3'd4, 12'h321, 1'b0, "R7");
    for (int i = 0; i < 11; i++) step(1'b0, 3'd1, 12'hFFF, 1'b1, "R7");
    step(1'b1, 3'd0, 12'd0, 1'b0, "R7");
    flush();
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #200us;
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    for (int k = 0; k < 4; k++) begin
      acc[k] = 0; pv[k] = 0; pd[k] = 0; ez[k] = 0; en[k] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b0, "R1", out_valid, 0);
    rst = 1'b0;
    t_reset();
    t_chain();
    t_interleave();
    t_zero();
    t_idle();
    finish_run();
  end
endmodule